// File: doc/BRIEF.md
# Dual-Period Duty-Cycle Pulse Counter

This block is the counting front end of a measuring instrument. It has two count sources. The first is a converter whose result arrives as a pulse-width-modulated data line together with a converter clock. The second is a comparator pulse line, used when the instrument measures frequency. In converter mode, each rising converter clock edge adds one count when the data level, corrected by the period flag, is active. During the first measuring period the flag is low and the data is counted as received. During the second period the flag is high and the data is inverted. The total over both periods is therefore the mean of the two periods, which cancels a constant offset. In frequency mode, the converter path is held inactive and each rising comparator edge adds one count.

Every input is brought into the system clock domain through a synchronizer and edge detector. The count is kept in a chain of cascaded BCD decade stages. A synchronous clear starts a measurement and also latches the count source, so one result never mixes counts from the two sources. A count enable defines the measuring window. A sticky overflow flag and a count-valid flag complete the result.

Top module: `duty_mean_counter`

## Requirements
- R1: After reset the count is zero on all digits, `overflow` and `count_valid` are low, and the converter source is the active one.
- R2: In converter mode with `period_flag` low, each rising edge of `conv_clk` adds one count when `conv_data` is high, and adds nothing when `conv_data` is low.
- R3: In converter mode with `period_flag` high, the data is inverted: each rising edge of `conv_clk` adds one count when `conv_data` is low, and adds nothing when it is high. Over a first and a second period, the total is the sum of both.
- R4: In frequency mode, each rising edge of `cmp_in` adds one count, and activity on `conv_clk` and `conv_data` adds nothing.
- R5: `count_bcd` holds one BCD digit per nibble, with digit i at bits [4i+3:4i] and the least significant digit at bits [3:0]. A digit that steps from 9 goes to 0 and carries one into the next digit. No digit ever shows a value above 9.
- R6: `overflow` is set when the most significant digit wraps from 9 to 0. It then stays set until a clear or a reset.
- R7: A cycle with `clear` high sets all digits to zero and sets `overflow` and `count_valid` low. While `clear` is high, no edge is counted.
- R8: While `count_en` is low, the count and `overflow` do not change.
- R9: The value on `mode_sel` (0 for converter, 1 for comparator) is taken as the source only in a clear cycle. A change of `mode_sel` without a clear has no effect.
- R10: `count_valid` goes high in the cycle after `count_en` falls. It goes low when `count_en` rises again or when a clear occurs.
- R11: An input edge is counted on the third system clock edge after it arrives. An input held high for many cycles counts only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 1 | Source selection taken at clear: 0 converter, 1 comparator |
| clear | input | 1 | Synchronous clear of the count, the flags and the mode latch |
| count_en | input | 1 | Measuring window; counting happens only while high |
| conv_clk | input | 1 | Converter clock, asynchronous |
| conv_data | input | 1 | Pulse-width-modulated converter data, asynchronous |
| period_flag | input | 1 | Low during the first measuring period, high during the second |
| cmp_in | input | 1 | Comparator pulse line, asynchronous |
| count_bcd | output | 4*NUM_DIGITS | BCD count, least significant digit in bits [3:0] |
| overflow | output | 1 | Sticky wrap flag of the top digit |
| count_valid | output | 1 | Result ready after the window closes |

## Verification
The assertions assume three things about the inputs. First, `conv_data` and `period_flag` settle at least two system cycles before the rising `conv_clk` edge they qualify, and they stay put until the edge has been counted. Second, every high and low phase of `conv_clk` and `cmp_in` lasts several system cycles. Third, `count_en` and `mode_sel` change only between counting edges. The stimulus keeps to these rules: it changes data and flag only while `conv_clk` is low, it holds every clock and comparator phase for at least three cycles, and it moves the enable and the mode only after an edge has been counted. Random runs draw the source, the data, the flag and the window positions from a fixed seed. Directed cases cover the decade carry, the top-digit wrap and a clear held over an edge.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

    typedef logic [3:0] bcd_t;

    localparam bcd_t BCD_TOP = 4'd9;

    // Decade step: 9 wraps to 0
    function automatic bcd_t bcd_next(bcd_t v);
        return (v >= BCD_TOP) ? 4'd0 : v + 4'd1;
    endfunction

endpackage

// File: rtl/dpc_sync.sv
// Multi-stage synchronizer; RISE selects a rising-edge pulse output
module dpc_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2,
    parameter bit RISE   = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] pipe;
    } sync_t;

    sync_t cur_q, nxt_d;

    always_comb begin
        nxt_d         = cur_q;
        nxt_d.pipe[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            nxt_d.pipe[i] = cur_q.pipe[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    generate
        if (RISE) begin : g_rise
            logic [WIDTH-1:0] last_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) last_q <= '0;
                else        last_q <= cur_q.pipe[STAGES-1];
            end
            assign q = cur_q.pipe[STAGES-1] & ~last_q;
        end else begin : g_level
            assign q = cur_q.pipe[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/dpc_count_source.sv
// Source selection in gate form: period-flag fold, clock gating, mode steering
module dpc_count_source (
    input  logic freq_mode,
    input  logic conv_rise,
    input  logic data_lvl,
    input  logic flag_lvl,
    input  logic cmp_rise,
    output logic pulse
);

    logic folded;
    logic conv_gate_n;
    logic conv_path_n;
    logic cmp_path_n;

    // Second period inverts the data
    assign folded      = data_lvl ^ flag_lvl;
    // Active-low gated converter tick
    assign conv_gate_n = ~(conv_rise & folded);
    // Frequency mode parks the converter path at its idle level
    assign conv_path_n = conv_gate_n | freq_mode;
    assign cmp_path_n  = ~(cmp_rise & freq_mode);
    // Final combining stage restores an active-high pulse
    assign pulse       = ~(conv_path_n & cmp_path_n);

endmodule

// File: rtl/dpc_decade_chain.sv
// Cascaded BCD decade stages with a sticky wrap flag
module dpc_decade_chain
    import dpc_pkg::*;
#(
    parameter int NUM_DIGITS = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    step,
    output logic [4*NUM_DIGITS-1:0] digits,
    output logic                    overflow
);

    typedef struct packed {
        logic [NUM_DIGITS-1:0][3:0] dig;
        logic                       ovf;
    } chain_t;

    chain_t cur_q, nxt_d;

    logic [NUM_DIGITS:0]        carry;
    logic [NUM_DIGITS-1:0][3:0] stepped;

    assign carry[0] = step;

    generate
        for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
            assign carry[g+1]  = carry[g] & (cur_q.dig[g] == BCD_TOP);
            assign stepped[g]  = carry[g] ? bcd_next(cur_q.dig[g]) : cur_q.dig[g];
        end
    endgenerate

    always_comb begin
        nxt_d = cur_q;
        if (clear) begin
            nxt_d.dig = '0;
            nxt_d.ovf = 1'b0;
        end else begin
            nxt_d.dig = stepped;
            nxt_d.ovf = cur_q.ovf | carry[NUM_DIGITS];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign digits   = cur_q.dig;
    assign overflow = cur_q.ovf;

endmodule

// File: rtl/duty_mean_counter.sv
module duty_mean_counter
    import dpc_pkg::*;
#(
    parameter int NUM_DIGITS  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mode_sel,
    input  logic                    clear,
    input  logic                    count_en,
    input  logic                    conv_clk,
    input  logic                    conv_data,
    input  logic                    period_flag,
    input  logic                    cmp_in,
    output logic [4*NUM_DIGITS-1:0] count_bcd,
    output logic                    overflow,
    output logic                    count_valid
);

    localparam int EDGE_W  = 2;
    localparam int LEVEL_W = 2;

    typedef struct packed {
        logic freq_mode;
        logic en_prev;
        logic valid;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic [EDGE_W-1:0]  edges;
    logic [LEVEL_W-1:0] levels;
    logic               pulse;
    logic               step;
    logic               active_mode;

    // Edge sources: bit 0 converter clock, bit 1 comparator
    dpc_sync #(
        .WIDTH  (EDGE_W),
        .STAGES (SYNC_STAGES),
        .RISE   (1'b1)
    ) u_edge_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({cmp_in, conv_clk}),
        .q     (edges)
    );

    // Level sources share the same depth so data lines up with its clock
    dpc_sync #(
        .WIDTH  (LEVEL_W),
        .STAGES (SYNC_STAGES),
        .RISE   (1'b0)
    ) u_level_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({period_flag, conv_data}),
        .q     (levels)
    );

    dpc_count_source u_source (
        .freq_mode (ctl_q.freq_mode),
        .conv_rise (edges[0]),
        .data_lvl  (levels[0]),
        .flag_lvl  (levels[1]),
        .cmp_rise  (edges[1]),
        .pulse     (pulse)
    );

    assign step = pulse & count_en & ~clear;

    dpc_decade_chain #(
        .NUM_DIGITS (NUM_DIGITS)
    ) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .step     (step),
        .digits   (count_bcd),
        .overflow (overflow)
    );

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.en_prev = count_en;
        if (clear) begin
            ctl_d.freq_mode = mode_sel;
            ctl_d.valid     = 1'b0;
        end else if (ctl_q.en_prev && !count_en) begin
            ctl_d.valid = 1'b1;
        end else if (!ctl_q.en_prev && count_en) begin
            ctl_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign active_mode = ctl_q.freq_mode;
    assign count_valid = ctl_q.valid;

endmodule

// File: rtl/dpc_checker.sv
module dpc_checker #(
    parameter int NUM_DIGITS = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    clear,
    input logic                    count_en,
    input logic                    mode_sel,
    input logic                    active_mode,
    input logic [4*NUM_DIGITS-1:0] count_bcd,
    input logic                    overflow,
    input logic                    count_valid
);

    function automatic logic digits_ok(logic [4*NUM_DIGITS-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < NUM_DIGITS; i++) begin
            if (v[4*i +: 4] > 4'd9) ok = 1'b0;
        end
        return ok;
    endfunction

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count_bcd == '0) && !overflow && !count_valid); // R7

    AST_FROZEN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_en && !clear) |=> $stable(count_bcd) && $stable(overflow)); // R8

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !clear) |=> overflow); // R6

    AST_DIGITS_BCD: assert property (@(posedge clk) disable iff (!rst_n)
        digits_ok(count_bcd)); // R5

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> $stable(active_mode)); // R9

    AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (active_mode == $past(mode_sel))); // R9

endmodule

bind duty_mean_counter dpc_checker #(.NUM_DIGITS(NUM_DIGITS)) u_dpc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (clear),
    .count_en    (count_en),
    .mode_sel    (mode_sel),
    .active_mode (active_mode),
    .count_bcd   (count_bcd),
    .overflow    (overflow),
    .count_valid (count_valid)
);

// File: tb/sim_duty_mean_counter.sv
`timescale 1ns/1ps
module sim_duty_mean_counter;

    localparam int DIG = 2;
    localparam int MOD = 100;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           mode_sel = 1'b0;
    logic           clear = 1'b0;
    logic           count_en = 1'b0;
    logic           conv_clk = 1'b0;
    logic           conv_data = 1'b0;
    logic           period_flag = 1'b0;
    logic           cmp_in = 1'b0;
    logic [4*DIG-1:0] count_bcd;
    logic           overflow;
    logic           count_valid;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int exp_cnt = 0;
    bit exp_ovf = 0;
    bit exp_mode = 0;
    bit exp_valid = 0;

    always #2.5 clk = ~clk;

    duty_mean_counter #(.NUM_DIGITS(DIG), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .clear(clear),
        .count_en(count_en), .conv_clk(conv_clk), .conv_data(conv_data),
        .period_flag(period_flag), .cmp_in(cmp_in), .count_bcd(count_bcd),
        .overflow(overflow), .count_valid(count_valid)
    );

    function automatic logic [4*DIG-1:0] to_bcd(int v);
        logic [4*DIG-1:0] r;
        int x;
        x = v % MOD;
        for (int i = 0; i < DIG; i++) begin
            r[4*i +: 4] = 4'(x % 10);
            x = x / 10;
        end
        return r;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_all(string req);
        chk({req, " count"}, 32'(count_bcd), 32'(to_bcd(exp_cnt)));
        chk({req, " overflow"}, 32'(overflow), 32'(exp_ovf));
        chk({req, " valid"}, 32'(count_valid), 32'(exp_valid));
    endtask

    function automatic void model_add();
        exp_cnt++;
        if (exp_cnt >= MOD) begin
            exp_cnt = exp_cnt - MOD;
            exp_ovf = 1'b1;
        end
    endfunction

    // One converter clock cycle: data and flag change while the clock is low
    task automatic conv_tick(bit d, bit f);
        @(negedge clk);
        conv_clk = 1'b0; conv_data = d; period_flag = f;
        repeat (3) @(negedge clk);
        conv_clk = 1'b1;
        repeat (3) @(negedge clk);
        if (!exp_mode && count_en && !clear && (d ^ f)) model_add();
    endtask

    task automatic cmp_tick(int hi);
        @(negedge clk);
        cmp_in = 1'b0;
        repeat (3) @(negedge clk);
        cmp_in = 1'b1;
        repeat (hi) @(negedge clk);
        if (exp_mode && count_en && !clear) model_add();
    endtask

    task automatic do_clear(bit m);
        @(negedge clk);
        mode_sel = m; clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        exp_cnt = 0; exp_ovf = 0; exp_mode = m; exp_valid = 0;
    endtask

    task automatic set_en(bit e);
        @(negedge clk);
        if (count_en && !e) exp_valid = 1'b1;
        if (!count_en && e) exp_valid = 1'b0;
        count_en = e;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (4) @(negedge clk);
        // R1 reset state
        chk_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1 after release");

        // R2 first period: count data-high ticks
        do_clear(1'b0);
        set_en(1'b1);
        repeat (5) conv_tick(1'b1, 1'b0);
        repeat (3) conv_tick(1'b0, 1'b0);
        chk_all("R2");

        // R3 second period: inverted data; total sums both periods
        repeat (4) conv_tick(1'b0, 1'b1);
        repeat (2) conv_tick(1'b1, 1'b1);
        chk_all("R3");

        // R5 decade carry 9 -> 10
        conv_tick(1'b0, 1'b1);
        chk("R5 carry", 32'(count_bcd), 32'h10);

        // R11 long high on conv_clk counts once
        conv_tick(1'b1, 1'b0);
        repeat (20) @(negedge clk);
        chk("R11 single count", 32'(count_bcd), 32'(to_bcd(exp_cnt)));

        // R10 valid after window closes; R8 freeze
        set_en(1'b0);
        chk("R10 valid set", 32'(count_valid), 32'd1);
        repeat (4) conv_tick(1'b1, 1'b0);
        chk_all("R8 frozen");
        set_en(1'b1);
        chk("R10 valid dropped", 32'(count_valid), 32'd0);

        // R9 mode change without clear is ignored
        @(negedge clk) mode_sel = 1'b1;
        repeat (3) cmp_tick(4);
        chk_all("R9 no switch");
        conv_tick(1'b1, 1'b0);
        chk_all("R9 still converter");

        // R4 frequency mode after clear
        do_clear(1'b1);
        chk_all("R7 clear");
        repeat (7) cmp_tick(3);
        repeat (3) conv_tick(1'b1, 1'b0);
        cmp_tick(25);
        chk_all("R4");

        // R6 wrap of the top digit
        do_clear(1'b0);
        repeat (105) conv_tick(1'b1, 1'b0);
        chk_all("R6 wrap");
        repeat (2) conv_tick(1'b0, 1'b0);
        chk("R6 sticky", 32'(overflow), 32'd1);

        // R7 clear held across a counting edge
        @(negedge clk);
        clear = 1'b1;
        conv_tick(1'b1, 1'b0);
        @(negedge clk);
        clear = 1'b0;
        exp_cnt = 0; exp_ovf = 0; exp_valid = 0;
        chk_all("R7 clear wins");

        // Random rounds across both sources
        for (int r = 0; r < 20; r++) begin
            do_clear(1'($urandom % 2));
            set_en(1'b1);
            for (int k = 0; k < 30; k++) begin
                int sel;
                sel = int'($urandom % 8);
                if (sel == 0) set_en(~count_en);
                else if (sel < 5) conv_tick(1'($urandom % 2), 1'($urandom % 2));
                else cmp_tick(3 + int'($urandom % 6));
            end
            chk_all(exp_mode ? "R4 random" : "R3 random");
            set_en(1'b0);
            chk_all("R10 random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule